// File: doc/BRIEF.md
# Integer ALU with Operation-Class Decoder

This block is a purely combinational integer arithmetic-logic unit with its own control decoder. The main sequencer supplies a 2-bit operation class, and the instruction supplies a 6-bit function field. The decoder turns these two inputs into a 4-bit control word. The ALU then applies that word to two operands and returns the result and a flag that shows whether the result is zero. A branch-on-equal decision is taken from this flag after a subtraction.

All six operations come from one shared core. The control word has three parts. Bit 3 inverts operand A. Bit 2 inverts operand B, and the same bit also forces the carry-in to 1. Bits 1:0 choose the output: 00 is bitwise AND, 01 is bitwise OR, 10 is the sum, and 11 is the signed less-than bit. With this scheme, subtract is an add with B inverted, set-less-than is a subtract whose sign bit goes to the output, and NOR is an AND of the two inverted operands.

The block has no state. The house state-machine layout therefore reduces to a single decode process and a single datapath process. There are no states and no transitions.

Top module: `alu_unit`

## Requirements
- R1: With operation class 00, the control word is 0010 (add) whatever the function field holds.
- R2: With operation class 01, the control word is 0110 (subtract) whatever the function field holds.
- R3: With operation class 10, the function field is decoded as follows: 100000 gives add 0010, 100010 gives subtract 0110, 100100 gives AND 0000, 100101 gives OR 0001, 101010 gives set-less-than 0111, and 100111 gives NOR 1100.
- R4: With operation class 10 and any function value not listed in R3, or with operation class 11, the control word is 0010 (add).
- R5: Control-word bit 3 (invert A) is 0 for every decoded word except NOR.
- R6: Control words 0000, 0001 and 1100 give A AND B, A OR B and NOT(A OR B), bit by bit.
- R7: Control word 0010 gives A+B and control word 0110 gives A−B, both modulo 2^WIDTH.
- R8: Control word 0111 gives 1 when A is less than B as signed two's-complement values, and 0 otherwise. The result stays correct when A−B overflows. Result bits above bit 0 are always 0.
- R9: The zero output is 1 exactly when every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 2 | Operation class from the main sequencer |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| ctrl_code | output | 4 | Decoded control word {invert A, invert B, select[1:0]} |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds two copies of the block. The first uses WIDTH=4. At this width it is practical to sweep every operand pair against every operation class and a set of listed and unlisted function codes. That sweep covers every signed-overflow case of set-less-than, every wrap of add and subtract, and every way of reaching a zero result. The second copy uses the default WIDTH=32. It is driven with chosen corner operands, such as the most negative value against positive values and all-ones patterns, to confirm that the carry chain and the sign correction scale to the full width.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        FS_AND  = 2'b00,
        FS_OR   = 2'b01,
        FS_ADD  = 2'b10,
        FS_LESS = 2'b11
    } fsel_e;

    typedef struct packed {
        logic  inv_a;
        logic  inv_b;
        fsel_e sel;
    } alu_ctrl_t;

    localparam logic [1:0] OPC_MEM    = 2'b00;
    localparam logic [1:0] OPC_BRANCH = 2'b01;
    localparam logic [1:0] OPC_FUNC   = 2'b10;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    localparam alu_ctrl_t CW_ADD = '{inv_a: 1'b0, inv_b: 1'b0, sel: FS_ADD};
    localparam alu_ctrl_t CW_SUB = '{inv_a: 1'b0, inv_b: 1'b1, sel: FS_ADD};
    localparam alu_ctrl_t CW_AND = '{inv_a: 1'b0, inv_b: 1'b0, sel: FS_AND};
    localparam alu_ctrl_t CW_OR  = '{inv_a: 1'b0, inv_b: 1'b0, sel: FS_OR};
    localparam alu_ctrl_t CW_SLT = '{inv_a: 1'b0, inv_b: 1'b1, sel: FS_LESS};
    localparam alu_ctrl_t CW_NOR = '{inv_a: 1'b1, inv_b: 1'b1, sel: FS_AND};

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [1:0] alu_op,
    input  logic [5:0] funct,
    output alu_ctrl_t  ctrl
);

    alu_ctrl_t func_ctrl;

    // Function-field decode, consulted only for the register class
    always_comb begin
        case (funct)
            FN_ADD:  func_ctrl = CW_ADD;
            FN_SUB:  func_ctrl = CW_SUB;
            FN_AND:  func_ctrl = CW_AND;
            FN_OR:   func_ctrl = CW_OR;
            FN_SLT:  func_ctrl = CW_SLT;
            FN_NOR:  func_ctrl = CW_NOR;
            default: func_ctrl = CW_ADD;
        endcase
    end

    always_comb begin
        unique case (alu_op)
            OPC_MEM:    ctrl = CW_ADD;
            OPC_BRANCH: ctrl = CW_SUB;
            OPC_FUNC:   ctrl = func_ctrl;
            default:    ctrl = CW_ADD;
        endcase
    end

    // Invert-A only appears for NOR
    always_comb begin
        if (ctrl.inv_a) begin
            AST_INV_A_ONLY_NOR: assert (alu_op == OPC_FUNC && funct == FN_NOR)
                else $error("invert-A outside NOR"); // R5
        end
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);

    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_or
            assign seen[i+1] = seen[i] | value[i];
        end
    endgenerate

    assign is_zero = ~seen[WIDTH];

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_m;
    logic [WIDTH-1:0] b_m;
    logic [WIDTH-1:0] sum;
    logic [WIDTH:0]   carry;
    logic             ovf;
    logic             less;

    assign carry[0] = ctrl.inv_b;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign a_m[i]     = a[i] ^ ctrl.inv_a;
            assign b_m[i]     = b[i] ^ ctrl.inv_b;
            assign sum[i]     = a_m[i] ^ b_m[i] ^ carry[i];
            assign carry[i+1] = (a_m[i] & b_m[i]) | (carry[i] & (a_m[i] ^ b_m[i]));
        end
    endgenerate

    // Sign of the difference, corrected when it overflows
    assign ovf  = carry[WIDTH] ^ carry[MSB];
    assign less = sum[MSB] ^ ovf;

    always_comb begin
        unique case (ctrl.sel)
            FS_AND:  y = a_m & b_m;
            FS_OR:   y = a_m | b_m;
            FS_ADD:  y = sum;
            FS_LESS: y = {{(WIDTH-1){1'b0}}, less};
            default: y = sum;
        endcase
    end

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       alu_op,
    input  logic [5:0]       funct,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [3:0]       ctrl_code,
    output logic [WIDTH-1:0] result,
    output logic             zero
);

    alu_ctrl_t ctrl;

    alu_op_decoder u_dec (
        .alu_op (alu_op),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    alu_core #(.WIDTH(WIDTH)) u_core (
        .ctrl (ctrl),
        .a    (opnd_a),
        .b    (opnd_b),
        .y    (result)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value   (result),
        .is_zero (zero)
    );

    assign ctrl_code = ctrl;

    always_comb begin
        if (alu_op == OPC_MEM) begin
            AST_MEM_CLASS_ADD: assert (ctrl_code == 4'b0010) else $error("class 00 not add"); // R1
        end
        if (alu_op == OPC_BRANCH) begin
            AST_BRANCH_CLASS_SUB: assert (ctrl_code == 4'b0110) else $error("class 01 not sub"); // R2
        end
        if (ctrl_code == 4'b0111) begin
            AST_SLT_UPPER_CLEAR: assert (result[WIDTH-1:1] == '0) else $error("slt upper bits"); // R8
        end
        if (ctrl_code == 4'b0110 && opnd_a == opnd_b) begin
            AST_EQUAL_SUB_ZERO: assert (zero) else $error("equal operands not zero"); // R9
        end
        if (ctrl_code == 4'b0000) begin
            AST_AND_SUBSET: assert ((result & ~opnd_a) == '0) else $error("and exceeds A"); // R6
        end
    end

endmodule

// File: tb/tb_alu_unit.sv
module tb_alu_unit;

    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [1:0]    alu_op;
    logic [5:0]    funct;
    logic [NW-1:0] a4, b4, r4;
    logic [WW-1:0] a32, b32, r32;
    logic [3:0]    c4, c32;
    logic          z4, z32;

    alu_unit #(.WIDTH(NW)) dut (
        .alu_op(alu_op), .funct(funct), .opnd_a(a4), .opnd_b(b4),
        .ctrl_code(c4), .result(r4), .zero(z4)
    );

    alu_unit #(.WIDTH(WW)) dut_w (
        .alu_op(alu_op), .funct(funct), .opnd_a(a32), .opnd_b(b32),
        .ctrl_code(c32), .result(r32), .zero(z32)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (op=%b fn=%b)", req, got, exp, alu_op, funct);
        end
    endtask

    function automatic logic [3:0] exp_code(input logic [1:0] op, input logic [5:0] f);
        if (op == 2'b00) return 4'b0010;          // R1
        if (op == 2'b01) return 4'b0110;          // R2
        if (op == 2'b11) return 4'b0010;          // R4
        case (f)                                  // R3
            6'b100000: return 4'b0010;
            6'b100010: return 4'b0110;
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b101010: return 4'b0111;
            6'b100111: return 4'b1100;
            default:   return 4'b0010;            // R4
        endcase
    endfunction

    function automatic logic [31:0] exp_res(input logic [3:0] cw, input logic [31:0] a,
                                            input logic [31:0] b, input int w);
        logic [31:0] m;
        longint sa, sb;
        logic [31:0] r;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
        sa = (a[w-1]) ? longint'(a) - (longint'(1) << w) : longint'(a);
        sb = (b[w-1]) ? longint'(b) - (longint'(1) << w) : longint'(b);
        case (cw)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1100: r = ~(a | b);
            4'b0010: r = a + b;
            4'b0110: r = a - b;
            4'b0111: r = (sa < sb) ? 32'd1 : 32'd0;
            default: r = 32'hDEAD_BEEF;
        endcase
        return r & m;
    endfunction

    function automatic string req_of(input logic [3:0] cw);
        case (cw)
            4'b0010, 4'b0110: return "R7";
            4'b0111:          return "R8";
            default:          return "R6";
        endcase
    endfunction

    logic [5:0] fn_list [10];

    initial begin
        fn_list[0] = 6'b100000; fn_list[1] = 6'b100010; fn_list[2] = 6'b100100;
        fn_list[3] = 6'b100101; fn_list[4] = 6'b101010; fn_list[5] = 6'b100111;
        fn_list[6] = 6'b000000; fn_list[7] = 6'b111111; fn_list[8] = 6'b100001;
        fn_list[9] = 6'b101011;

        alu_op = 2'b00; funct = 6'b0; a4 = '0; b4 = '0; a32 = '0; b32 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle-input state
        check("R1", {28'd0, c4}, 32'h2);
        check("R9", {31'd0, z4}, 32'd1);
        check("R7", {28'd0, r4}, 32'd0);

        // Exhaustive narrow sweep
        for (int op = 0; op < 4; op++) begin
            for (int fi = 0; fi < 10; fi++) begin
                for (int av = 0; av < 16; av++) begin
                    for (int bv = 0; bv < 16; bv++) begin
                        logic [3:0]  ec;
                        logic [31:0] er;
                        alu_op = op[1:0]; funct = fn_list[fi];
                        a4 = av[3:0]; b4 = bv[3:0];
                        @(negedge clk);
                        ec = exp_code(alu_op, funct);
                        check((op == 2) ? "R3" : (op == 0 ? "R1" : (op == 1 ? "R2" : "R4")),
                              {28'd0, c4}, {28'd0, ec});
                        check("R5", {31'd0, c4[3]}, {31'd0, ec == 4'b1100});
                        er = exp_res(ec, {28'd0, a4}, {28'd0, b4}, NW);
                        check(req_of(ec), {28'd0, r4}, er);
                        check("R9", {31'd0, z4}, {31'd0, er == 32'd0});
                    end
                end
            end
        end

        // Wide corner operands
        alu_op = 2'b10;
        for (int fi = 0; fi < 6; fi++) begin
            for (int k = 0; k < 6; k++) begin
                logic [31:0] av, bv, er;
                case (k)
                    0: begin av = 32'h8000_0000; bv = 32'h0000_0001; end
                    1: begin av = 32'h7FFF_FFFF; bv = 32'h8000_0000; end
                    2: begin av = 32'hFFFF_FFFF; bv = 32'h0000_0001; end
                    3: begin av = 32'h1234_5678; bv = 32'h1234_5678; end
                    4: begin av = 32'h8000_0000; bv = 32'h7FFF_FFFF; end
                    default: begin av = 32'hA5A5_0F0F; bv = 32'h5A5A_F0F0; end
                endcase
                funct = fn_list[fi]; a32 = av; b32 = bv;
                @(negedge clk);
                er = exp_res(exp_code(alu_op, funct), av, bv, WW);
                check(req_of(exp_code(alu_op, funct)), r32, er);
                check("R9", {31'd0, z32}, {31'd0, er == 32'd0});
            end
        end
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected done", cycles);
            done = 1'b1;
        end
    end

    initial begin
        wait (done);
        #1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule